// File: doc/BRIEF.md
# Four-State Snooping Coherence Controller

This block keeps the coherence state of each line in a small direct-mapped write-back cache that sits on a shared snooping bus. Each line is in one of four states: invalid, clean-sharable, clean-exclusive or dirty-exclusive. The block serves processor reads and writes. It issues bus transactions when a line must be fetched, upgraded or written back. It also watches the transactions that other caches put on the bus, answers them with a shared indication and a data-supply request, and downgrades or drops its own copies as those transactions require.

The directory holding tags and states has two independent lookup ports. A snooped transaction is checked in the same cycle as a processor access. The processor side is held back only when both touch the same line. Data storage, memory timing and bus arbitration are outside the block. The processor holds its request until `cpu_done` pulses. The block holds `bus_req` with its operation and address until `bus_gnt` marks that transaction complete. In the grant cycle, `bus_shared_in` carries the combined shared response of the other caches. The arbiter never grants this block in a cycle that carries a snooped transaction.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid (all of `line_state` is zero), and `bus_req` and `cpu_done` are low. The per-line state codes, two bits per line with line i at bits [2i+1:2i], are invalid=0, clean-sharable=1, clean-exclusive=2, dirty-exclusive=3.
- R2: A read miss issues a bus read (op code 0) to the requested address. `cpu_done` is asserted in the grant cycle. The line is filled as clean-exclusive when `bus_shared_in` is low at grant, and as clean-sharable when it is high. The address is {tag, index}, with the index in the low bits.
- R3: A write that hits a clean-exclusive or dirty-exclusive line completes in the cycle it is presented, raises no bus request and leaves the line dirty-exclusive.
- R4: A write that hits a clean-sharable line issues an address-only invalidate (op code 2) to that address. At grant it completes and the line becomes dirty-exclusive.
- R5: A write miss issues a read-for-write (op code 1) to the requested address. At grant it completes and the line is filled as dirty-exclusive.
- R6: A miss whose indexed line is dirty-exclusive first issues a write-back (op code 3) to the victim's address. The fetch follows only after that grant. A miss whose victim is clean or invalid goes straight to the fetch.
- R7: A snooped read (op 0) that hits a valid line raises `snp_shared` in the same cycle. `snp_supply` is raised as well when the line is dirty-exclusive. The line then becomes clean-sharable.
- R8: A snooped read-for-write (op 1) or invalidate (op 2) that hits a line invalidates it. `snp_supply` is raised for a read-for-write that hits a dirty-exclusive line.
- R9: A snooped transaction that misses (tag differs or line invalid), or a snooped write-back (op 3), raises neither response and changes no line.
- R10: A processor access is stalled (no `cpu_done`, no state change) in any cycle where a snoop hits the same line. Accesses to other lines proceed in the same cycle as the snoop.
- R11: A pending upgrade or write-back whose line is hit by a snoop before grant withdraws `bus_req` in that cycle. The access then restarts from lookup with the line's new state.
- R12: A read that hits any valid line completes in the cycle it is presented, with no bus request and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor access present; held until `cpu_done` |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Block address {tag, index} |
| cpu_done | output | 1 | Access completes this cycle |
| bus_req | output | 1 | Bus transaction requested |
| bus_op | output | 2 | 0 read, 1 read-for-write, 2 invalidate, 3 write-back |
| bus_addr | output | ADDR_W | Address of the requested transaction |
| bus_gnt | input | 1 | Requested transaction completes this cycle |
| bus_shared_in | input | 1 | Another cache holds the block (valid with grant) |
| snp_valid | input | 1 | Snooped transaction present |
| snp_op | input | 2 | Snooped operation, same codes as `bus_op` |
| snp_addr | input | ADDR_W | Snooped block address |
| snp_shared | output | 1 | This cache holds a valid copy of a snooped read |
| snp_supply | output | 1 | This cache must supply or write back the dirty block |
| line_state | output | 2*LINES | Current state code of each line |

## Verification
Directed sequences walk one line through every transition: a read miss with and without a shared answer, a silent and a bus-assisted upgrade, a write miss, and a dirty and a clean victim. The dirty and clean victims show whether a write-back is issued only when required. Snoops of each kind are aimed at exclusive, dirty and shared lines, at a mismatching tag and at an invalid line. These separate a real hit from a mere index match, and tell supply apart from the shared answer. Collisions between a snoop and a processor access are staged on the same line and on different lines, including a snoop that arrives while an upgrade waits for the bus. Seeded random traffic then mixes accesses and snoops over a few tags per index so that victims, refills and downgrades interleave.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I  = 2'd0,
        ST_CS = 2'd1,
        ST_CE = 2'd2,
        ST_DE = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_RFO = 2'd1,
        OP_INV = 2'd2,
        OP_WB  = 2'd3
    } bus_op_e;

    // state a held line takes after another cache's transaction
    function automatic line_st_e snoop_next(line_st_e s, bus_op_e op);
        case (op)
            OP_RD:          return (s == ST_I) ? ST_I : ST_CS;
            OP_RFO, OP_INV: return ST_I;
            default:        return s;
        endcase
    endfunction

    // state of a freshly fetched line
    function automatic line_st_e fill_state(logic wr, logic shared);
        if (wr)     return ST_DE;
        if (shared) return ST_CS;
        return ST_CE;
    endfunction

endpackage

// File: rtl/mesi_dir.sv
module mesi_dir
    import mesi_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 6,
    localparam int LINES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] cpu_idx,
    output line_st_e         cpu_st,
    output logic [TAG_W-1:0] cpu_tag,
    input  logic [IDX_W-1:0] snp_idx,
    output line_st_e         snp_st,
    output logic [TAG_W-1:0] snp_tag,
    input  logic             cpu_we,
    input  logic [IDX_W-1:0] cpu_widx,
    input  logic [TAG_W-1:0] cpu_wtag,
    input  line_st_e         cpu_wst,
    input  logic             snp_we,
    input  logic [IDX_W-1:0] snp_widx,
    input  line_st_e         snp_wst,
    output logic [2*LINES-1:0] state_vec
);
    line_st_e         st_q  [LINES];
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (rst) begin
                st_q[i]  <= ST_I;
                tag_q[i] <= '0;
            end else if (cpu_we && cpu_widx == IDX_W'(i)) begin
                st_q[i]  <= cpu_wst;
                tag_q[i] <= cpu_wtag;
            end else if (snp_we && snp_widx == IDX_W'(i)) begin
                st_q[i]  <= snp_wst;
            end
        end
    end

    assign cpu_st  = st_q[cpu_idx];
    assign cpu_tag = tag_q[cpu_idx];
    assign snp_st  = st_q[snp_idx];
    assign snp_tag = tag_q[snp_idx];

    for (genvar g = 0; g < LINES; g++) begin : g_vec
        assign state_vec[2*g +: 2] = st_q[g];
    end

    // R10: the stall rule keeps the two write ports off the same line
    a_r10_one_writer: assert property (@(posedge clk) disable iff (rst)
        !(cpu_we && snp_we && cpu_widx == snp_widx));

endmodule

// File: rtl/mesi_snoop.sv
module mesi_snoop
    import mesi_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             snp_valid,
    input  bus_op_e          snp_op,
    input  logic [TAG_W-1:0] snp_tag_in,
    input  line_st_e         dir_st,
    input  logic [TAG_W-1:0] dir_tag,
    output logic             snp_hit,
    output logic             snp_shared,
    output logic             snp_supply,
    output logic             snp_we,
    output line_st_e         snp_wst
);
    always_comb begin
        snp_hit    = snp_valid && dir_st != ST_I && dir_tag == snp_tag_in;
        snp_shared = snp_hit && snp_op == OP_RD;
        snp_supply = snp_hit && dir_st == ST_DE && (snp_op == OP_RD || snp_op == OP_RFO);
        snp_wst    = snoop_next(dir_st, snp_op);
        snp_we     = snp_hit && snp_wst != dir_st;
    end
endmodule

// File: rtl/mesi_cpu_fsm.sv
module mesi_cpu_fsm
    import mesi_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 6,
    localparam int ADDR_W = IDX_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic [TAG_W-1:0]  cpu_tag,
    input  line_st_e          dir_st,
    input  logic [TAG_W-1:0]  dir_tag,
    input  logic              snp_block,
    input  logic              bus_gnt,
    input  logic              bus_shared_in,
    output logic              cpu_done,
    output logic              bus_req,
    output bus_op_e           bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              wr_en,
    output logic [TAG_W-1:0]  wr_tag,
    output line_st_e          wr_st
);
    typedef enum logic [1:0] {S_IDLE, S_WB, S_FETCH, S_UPG} fsm_e;
    fsm_e st_q, st_d;
    logic hit;

    always_comb begin
        hit      = dir_st != ST_I && dir_tag == cpu_tag;
        st_d     = st_q;
        cpu_done = 1'b0;
        bus_req  = 1'b0;
        bus_op   = OP_RD;
        bus_addr = {cpu_tag, cpu_idx};
        wr_en    = 1'b0;
        wr_tag   = cpu_tag;
        wr_st    = ST_DE;
        case (st_q)
            S_IDLE: if (cpu_valid && !snp_block) begin
                if (hit) begin
                    if (!cpu_write) cpu_done = 1'b1;
                    else if (dir_st == ST_CS) st_d = S_UPG;
                    else begin
                        cpu_done = 1'b1;
                        wr_en    = 1'b1;
                    end
                end else begin
                    st_d = (dir_st == ST_DE) ? S_WB : S_FETCH;
                end
            end
            S_WB: if (snp_block) st_d = S_IDLE;
            else begin
                bus_req  = 1'b1;
                bus_op   = OP_WB;
                bus_addr = {dir_tag, cpu_idx};
                if (bus_gnt) begin
                    wr_en  = 1'b1;
                    wr_tag = dir_tag;
                    wr_st  = ST_I;
                    st_d   = S_FETCH;
                end
            end
            S_FETCH: begin
                bus_req = 1'b1;
                bus_op  = cpu_write ? OP_RFO : OP_RD;
                if (bus_gnt) begin
                    wr_en    = 1'b1;
                    wr_st    = fill_state(cpu_write, bus_shared_in);
                    cpu_done = 1'b1;
                    st_d     = S_IDLE;
                end
            end
            default: if (snp_block) st_d = S_IDLE;
            else begin
                bus_req = 1'b1;
                bus_op  = OP_INV;
                if (bus_gnt) begin
                    wr_en    = 1'b1;
                    cpu_done = 1'b1;
                    st_d     = S_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= S_IDLE;
        else     st_q <= st_d;
    end

    // R4: an invalidate is only ever requested for a shared copy of the target
    a_r4_inv_from_shared: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_op == OP_INV) |-> (dir_st == ST_CS && dir_tag == cpu_tag));

    // R6: a write-back is only requested while the victim is still dirty
    a_r6_wb_only_dirty: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_op == OP_WB) |-> dir_st == ST_DE);

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    localparam int TAG_W = ADDR_W - IDX_W,
    localparam int LINES = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_valid,
    input  logic               cpu_write,
    input  logic [ADDR_W-1:0]  cpu_addr,
    output logic               cpu_done,
    output logic               bus_req,
    output logic [1:0]         bus_op,
    output logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_gnt,
    input  logic               bus_shared_in,
    input  logic               snp_valid,
    input  logic [1:0]         snp_op,
    input  logic [ADDR_W-1:0]  snp_addr,
    output logic               snp_shared,
    output logic               snp_supply,
    output logic [2*LINES-1:0] line_state
);
    logic [IDX_W-1:0] cpu_idx, snp_idx;
    logic [TAG_W-1:0] cpu_tag, snp_tag, dcpu_tag, dsnp_tag, wr_tag;
    line_st_e         dcpu_st, dsnp_st, wr_st, snp_wst;
    bus_op_e          op_e;
    logic             snp_hit, snp_we, wr_en, snp_block;

    assign cpu_idx   = cpu_addr[IDX_W-1:0];
    assign cpu_tag   = cpu_addr[ADDR_W-1:IDX_W];
    assign snp_idx   = snp_addr[IDX_W-1:0];
    assign snp_tag   = snp_addr[ADDR_W-1:IDX_W];
    assign snp_block = snp_hit && snp_idx == cpu_idx;
    assign bus_op    = op_e;

    mesi_dir #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_dir (
        .clk(clk), .rst(rst),
        .cpu_idx(cpu_idx), .cpu_st(dcpu_st), .cpu_tag(dcpu_tag),
        .snp_idx(snp_idx), .snp_st(dsnp_st), .snp_tag(dsnp_tag),
        .cpu_we(wr_en), .cpu_widx(cpu_idx), .cpu_wtag(wr_tag), .cpu_wst(wr_st),
        .snp_we(snp_we), .snp_widx(snp_idx), .snp_wst(snp_wst),
        .state_vec(line_state)
    );

    mesi_snoop #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid(snp_valid), .snp_op(bus_op_e'(snp_op)), .snp_tag_in(snp_tag),
        .dir_st(dsnp_st), .dir_tag(dsnp_tag),
        .snp_hit(snp_hit), .snp_shared(snp_shared), .snp_supply(snp_supply),
        .snp_we(snp_we), .snp_wst(snp_wst)
    );

    mesi_cpu_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_fsm (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write),
        .cpu_idx(cpu_idx), .cpu_tag(cpu_tag),
        .dir_st(dcpu_st), .dir_tag(dcpu_tag), .snp_block(snp_block),
        .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
        .cpu_done(cpu_done), .bus_req(bus_req), .bus_op(op_e), .bus_addr(bus_addr),
        .wr_en(wr_en), .wr_tag(wr_tag), .wr_st(wr_st)
    );

    function automatic logic [1:0] st_at(logic [2*LINES-1:0] v, logic [IDX_W-1:0] i);
        return v[2*i +: 2];
    endfunction

    // R2: a completed access leaves its line holding a valid copy
    a_r2_done_line_valid: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> st_at(line_state, $past(cpu_idx)) != 2'd0);

    // R8: a snooped read-for-write that hits always drops the line
    a_r8_rfo_drops_line: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_hit && snp_op == 2'd1 && !bus_gnt)
        |=> st_at(line_state, $past(snp_idx)) == 2'd0);

endmodule

// File: tb/mesi_snoop_ctrl_test.sv
module mesi_snoop_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int IDX_W  = 2;
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int LINES  = 1 << IDX_W;
    localparam logic [1:0] I = 2'd0, CS = 2'd1, CE = 2'd2, DE = 2'd3;
    localparam logic [1:0] RD = 2'd0, RFO = 2'd1, INV = 2'd2, WB = 2'd3;

    logic clk = 1'b0, rst = 1'b1;
    logic cpu_valid = 0, cpu_write = 0, bus_gnt = 0, bus_shared_in = 0, snp_valid = 0;
    logic [ADDR_W-1:0] cpu_addr = '0, snp_addr = '0;
    logic [1:0] snp_op = '0;
    logic cpu_done, bus_req, snp_shared, snp_supply;
    logic [1:0] bus_op;
    logic [ADDR_W-1:0] bus_addr;
    logic [2*LINES-1:0] line_state;

    int checks = 0, fails = 0;
    logic [1:0]       m_st  [LINES];
    logic [TAG_W-1:0] m_tag [LINES];

    mesi_snoop_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) uut (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
        .cpu_addr(cpu_addr), .cpu_done(cpu_done), .bus_req(bus_req), .bus_op(bus_op),
        .bus_addr(bus_addr), .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_supply(snp_supply), .line_state(line_state)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [2*LINES-1:0] model_vec();
        logic [2*LINES-1:0] v;
        for (int i = 0; i < LINES; i++) v[2*i +: 2] = m_st[i];
        return v;
    endfunction

    task automatic check_lines(input string req);
        check(line_state == model_vec(), req, "line states", line_state, model_vec());
    endtask

    function automatic logic m_hit(input logic [ADDR_W-1:0] a);
        return m_st[a[IDX_W-1:0]] != I && m_tag[a[IDX_W-1:0]] == a[ADDR_W-1:IDX_W];
    endfunction

    function automatic void m_snoop(input logic [1:0] op, input logic [ADDR_W-1:0] a);
        if (m_hit(a)) begin
            if (op == RD) m_st[a[IDX_W-1:0]] = CS;
            else if (op != WB) m_st[a[IDX_W-1:0]] = I;
        end
    endfunction

    // Runs a processor access from the current negedge until it completes.
    task automatic cpu_run(input logic w, input logic [ADDR_W-1:0] a, input logic sh,
                           input string req);
        logic [1:0] eop [2];
        logic [ADDR_W-1:0] ead [2];
        int n = 0, k = 0;
        bit done = 0;
        logic [IDX_W-1:0] ix = a[IDX_W-1:0];
        if (m_hit(a)) begin
            if (w && m_st[ix] == CS) begin eop[0] = INV; ead[0] = a; n = 1; end
        end else begin
            if (m_st[ix] == DE) begin eop[n] = WB; ead[n] = {m_tag[ix], ix}; n++; end
            eop[n] = w ? RFO : RD; ead[n] = a; n++;
        end
        cpu_valid = 1; cpu_write = w; cpu_addr = a;
        for (int c = 0; c < 16 && !done; c++) begin
            #1;
            if (bus_req) begin
                check(k < n && bus_op == eop[k], req, "bus op", bus_op, (k < n) ? eop[k] : 2'bx);
                check(k < n && bus_addr == ead[k], req, "bus addr", bus_addr, (k < n) ? ead[k] : 'x);
                bus_gnt = 1; bus_shared_in = sh;
                #1;
                check(cpu_done == (k == n - 1), req, "done at grant", cpu_done, k == n - 1);
                done = cpu_done; k++;
            end else if (cpu_done) begin
                check(n == 0, req, "done without bus", n, 0);
                done = 1;
            end
            @(negedge clk);
            bus_gnt = 0; bus_shared_in = 0;
        end
        cpu_valid = 0;
        check(done && k == n, req, "ops completed", k, n);
        if (m_hit(a)) begin
            if (w) m_st[ix] = DE;
        end else begin
            m_tag[ix] = a[ADDR_W-1:IDX_W];
            m_st[ix]  = w ? DE : (sh ? CS : CE);
        end
        #1 check_lines(req);
    endtask

    task automatic cpu_op(input logic w, input logic [ADDR_W-1:0] a, input logic sh,
                          input string req);
        @(negedge clk);
        cpu_run(w, a, sh, req);
    endtask

    task automatic snoop_op(input logic [1:0] op, input logic [ADDR_W-1:0] a, input string req);
        logic esh, esu;
        @(negedge clk);
        snp_valid = 1; snp_op = op; snp_addr = a;
        esh = m_hit(a) && op == RD;
        esu = m_hit(a) && m_st[a[IDX_W-1:0]] == DE && (op == RD || op == RFO);
        #1;
        check(snp_shared == esh, req, "snp_shared", snp_shared, esh);
        check(snp_supply == esu, req, "snp_supply", snp_supply, esu);
        @(negedge clk);
        snp_valid = 0;
        m_snoop(op, a);
        #1 check_lines(req);
    endtask

    function automatic logic [ADDR_W-1:0] ad(input int tag, input int idx);
        return {TAG_W'(tag), IDX_W'(idx)};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < LINES; i++) begin m_st[i] = I; m_tag[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        check(line_state == '0, "R1", "line states", line_state, 0);
        check(!bus_req && !cpu_done, "R1", "idle outputs", {bus_req, cpu_done}, 0);

        cpu_op(0, ad(1, 0), 0, "R2");      // exclusive fill
        cpu_op(1, ad(1, 0), 0, "R3");      // silent upgrade
        cpu_op(0, ad(1, 1), 1, "R2");      // shared fill
        cpu_op(1, ad(1, 1), 0, "R4");      // invalidate upgrade
        cpu_op(1, ad(1, 2), 0, "R5");      // write miss
        cpu_op(0, ad(1, 0), 0, "R12");     // read hit on dirty line
        cpu_op(1, ad(1, 0), 0, "R3");      // write hit on dirty line
        cpu_op(0, ad(2, 0), 0, "R6");      // dirty victim: write-back then read
        cpu_op(0, ad(3, 0), 0, "R6");      // clean victim: read only
        snoop_op(RD,  ad(1, 1), "R7");     // dirty line: shared + supply
        snoop_op(RD,  ad(3, 0), "R7");     // exclusive line: shared only
        cpu_op(0, ad(3, 0), 0, "R12");     // read hit on shared line
        snoop_op(RFO, ad(1, 2), "R8");     // dirty line: supply, drop
        snoop_op(INV, ad(1, 1), "R8");     // shared line: drop
        snoop_op(RD,  ad(5, 0), "R9");     // tag mismatch
        snoop_op(RD,  ad(1, 2), "R9");     // invalid line
        snoop_op(WB,  ad(3, 0), "R9");     // write-back op ignored

        // R10 same-line collision: snoop read hits exclusive line while CPU writes
        cpu_op(0, ad(1, 1), 0, "R10");
        @(negedge clk);
        cpu_valid = 1; cpu_write = 1; cpu_addr = ad(1, 1);
        snp_valid = 1; snp_op = RD; snp_addr = ad(1, 1);
        #1;
        check(!cpu_done && !bus_req, "R10", "stalled by snoop", {cpu_done, bus_req}, 0);
        check(snp_shared, "R10", "snoop answered", snp_shared, 1);
        @(negedge clk);
        snp_valid = 0;
        m_snoop(RD, ad(1, 1));
        #1 check_lines("R10");
        cpu_run(1, ad(1, 1), 0, "R10");    // now shared: needs invalidate

        // R10 different lines proceed together
        @(negedge clk);
        cpu_valid = 1; cpu_write = 0; cpu_addr = ad(1, 1);
        snp_valid = 1; snp_op = INV; snp_addr = ad(3, 0);
        #1;
        check(cpu_done && !bus_req, "R10", "other line proceeds", {cpu_done, bus_req}, 2'b10);
        @(negedge clk);
        snp_valid = 0; cpu_valid = 0;
        m_snoop(INV, ad(3, 0));
        #1 check_lines("R10");

        // R11 pending upgrade withdrawn by a snooped invalidate
        cpu_op(0, ad(2, 3), 1, "R11");
        @(negedge clk);
        cpu_valid = 1; cpu_write = 1; cpu_addr = ad(2, 3);
        @(negedge clk);
        #1;
        check(bus_req && bus_op == INV, "R11", "upgrade pending", {bus_req, bus_op}, {1'b1, INV});
        snp_valid = 1; snp_op = INV; snp_addr = ad(2, 3);
        #1;
        check(!bus_req, "R11", "request withdrawn", bus_req, 0);
        @(negedge clk);
        snp_valid = 0;
        m_snoop(INV, ad(2, 3));
        cpu_run(1, ad(2, 3), 0, "R11");    // restarts as a write miss

        // R11 pending write-back withdrawn when a snooped read cleans the victim
        cpu_op(1, ad(1, 2), 0, "R11");
        @(negedge clk);
        cpu_valid = 1; cpu_write = 0; cpu_addr = ad(4, 2);
        @(negedge clk);
        #1;
        check(bus_req && bus_op == WB, "R11", "write-back pending", {bus_req, bus_op}, {1'b1, WB});
        snp_valid = 1; snp_op = RD; snp_addr = ad(1, 2);
        #1;
        check(!bus_req && snp_supply, "R11", "withdrawn, supplied", {bus_req, snp_supply}, 2'b01);
        @(negedge clk);
        snp_valid = 0;
        m_snoop(RD, ad(1, 2));
        cpu_run(0, ad(4, 2), 0, "R11");    // victim clean now: read only

        // seeded random mix
        for (int it = 0; it < 400; it++) begin
            logic [ADDR_W-1:0] a = ad($urandom % 3, $urandom % LINES);
            if ($urandom % 3 == 0) snoop_op(2'($urandom % 4), a, "R7/R8/R9 random");
            else cpu_op(1'($urandom % 2), a, 1'($urandom % 2), "R2-R6 random");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule